// File: doc/BRIEF.md
# Lowest-Pending Channel Interrupt Selector

This block is the interrupt status and clear point of a multi-channel DMA controller. Each channel keeps four sticky interrupt flags: error, done, paused and data-integrity error. The flags are set by one-cycle pulses from the channel engines. Each channel also drives three live status levels: pending, busy and descriptor-fault. A single 16-bit word shows one channel at a time: its number, its flags and its status levels. A shared interrupt handler reads that word to learn which channel to serve first.

The channel shown is, by default, the lowest-numbered channel that has a paused, done or error flag set. Software can write a channel number to look at any channel. That view stays until one of two things happens: a lower channel newly raises a flag, or software clears flags. Writing ones to the flag bits of the word clears those flags in the channel named by the same write. The `irq` output stays high while any channel has a paused, done or error flag set.

Top module: `dma_irq_pend_sel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, all flags are cleared, `irq` is low and `rd_data` reads 0x0000 when the status inputs are low.
- R2: `rd_data` layout: bit 15 pending, 14 busy, 13 descriptor-fault, 12 data-integrity error, 10 paused, 9 done, 8 error, 4:0 channel ID. Bits 11 and 7:5 always read 0.
- R3: Bits 15:13 show the live `stat_pend`, `stat_busy` and `stat_fault` inputs of the channel named by the ID field.
- R4: A one-cycle set pulse on a channel sets that flag on the next clock edge. The flag stays set until it is cleared.
- R5: A write with bit 12, 10, 9 or 8 equal to 1 clears that flag in the channel named by `wr_data[4:0]`. A 0 in those bits leaves the flag unchanged.
- R6: If a set pulse and a clear reach the same flag in the same cycle, the flag ends up set.
- R7: In automatic mode, the ID field follows the lowest channel with a paused, done or error flag, one cycle after the flags change.
- R8: In automatic mode with no channel pending, the ID field reads 0.
- R9: A write loads `wr_data[4:0]` into the ID field on the next edge. If that write clears nothing, the block enters view mode and keeps that ID.
- R10: In view mode, a channel below the viewed one newly becoming pending moves the ID to the lowest pending channel and returns the block to automatic mode.
- R11: A write with any clear bit set returns the block to automatic mode from the following cycle.
- R12: `irq` is high exactly while some channel has a paused, done or error flag set. It falls only as a result of a write.
- R13: An ID at or above `NCH` reads all flags and status as 0, and a clear aimed at it changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word: clear bits and channel ID |
| rd_data | output | 16 | Status word of the selected channel |
| set_err | input | NCH | Per-channel error flag set pulses |
| set_done | input | NCH | Per-channel done flag set pulses |
| set_pause | input | NCH | Per-channel paused flag set pulses |
| set_integ | input | NCH | Per-channel data-integrity flag set pulses |
| stat_pend | input | NCH | Per-channel pending status level |
| stat_busy | input | NCH | Per-channel busy status level |
| stat_fault | input | NCH | Per-channel descriptor-fault level |
| irq | output | 1 | High while any channel has a pending flag |

## Verification
The bench targets these corner cases, and what a faulty design would show in each:
- A set pulse and a clear hit the same flag in the same cycle. A design that lets the clear win loses the event, and `irq` goes low.
- In view mode, a lower channel raises a flag. A design that ignores it stays on the viewed channel. A channel above the viewed one raises a flag. A design that jumps on it leaves the view.
- Flags are cleared one channel after another until none is left. A wrong tracker shows a stale ID, or a non-zero ID once nothing is pending.
- A write names a channel that does not exist. A design that aliases the index shows, or clears, the flags of a real channel.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    localparam int ID_W    = 5;
    localparam int WORD_W  = 16;
    localparam int MAX_CH  = 32;

    localparam int B_PEND  = 15;
    localparam int B_BUSY  = 14;
    localparam int B_FAULT = 13;
    localparam int B_INTEG = 12;
    localparam int B_PAUSE = 10;
    localparam int B_DONE  = 9;
    localparam int B_ERR   = 8;

    typedef struct packed {
        logic integ;
        logic pause;
        logic done;
        logic err;
    } ch_flags_t;

    typedef struct packed {
        logic pend;
        logic busy;
        logic fault;
    } ch_stat_t;

    function automatic logic flags_pending(ch_flags_t f);
        return f.pause | f.done | f.err;
    endfunction

    function automatic ch_flags_t clear_mask(logic [WORD_W-1:0] w);
        ch_flags_t m;
        m.integ = w[B_INTEG];
        m.pause = w[B_PAUSE];
        m.done  = w[B_DONE];
        m.err   = w[B_ERR];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(ch_flags_t f, ch_stat_t s,
                                                    logic [ID_W-1:0] id);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[B_PEND]   = s.pend;
        w[B_BUSY]   = s.busy;
        w[B_FAULT]  = s.fault;
        w[B_INTEG]  = f.integ;
        w[B_PAUSE]  = f.pause;
        w[B_DONE]   = f.done;
        w[B_ERR]    = f.err;
        w[ID_W-1:0] = id;
        return w;
    endfunction

endpackage

// File: rtl/irqsel_flag_bank.sv
module irqsel_flag_bank
    import irqsel_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          set_err,
    input  logic [NCH-1:0]          set_done,
    input  logic [NCH-1:0]          set_pause,
    input  logic [NCH-1:0]          set_integ,
    input  logic                    clr_en,
    input  logic [ID_W-1:0]         clr_ch,
    input  ch_flags_t               clr_bits,
    output ch_flags_t [NCH-1:0]     flags,
    output logic [NCH-1:0]          pend_vec
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_flags_t set_here;
        ch_flags_t clr_here;

        always_comb begin
            set_here.integ = set_integ[c];
            set_here.pause = set_pause[c];
            set_here.done  = set_done[c];
            set_here.err   = set_err[c];
            clr_here = (clr_en && clr_ch == ID_W'(c)) ? clr_bits : '0;
        end

        // set is applied after clear so a coincident event survives
        always_ff @(posedge clk) begin
            if (rst) flags[c] <= '0;
            else     flags[c] <= (flags[c] & ~clr_here) | set_here;
        end

        assign pend_vec[c] = flags_pending(flags[c]);
    end

endmodule

// File: rtl/irqsel_prio_enc.sv
module irqsel_prio_enc
    import irqsel_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0]  req,
    output logic            found,
    output logic [ID_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (req[c]) begin
                found = 1'b1;
                idx   = ID_W'(c);
            end
        end
    end

endmodule

// File: rtl/irqsel_id_track.sv
module irqsel_id_track
    import irqsel_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCH-1:0]  pend_vec,
    input  logic            any_pend,
    input  logic [ID_W-1:0] lowest,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  logic            wr_clears,
    output logic [ID_W-1:0] sel_id,
    output logic            hold
);

    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] below;
    logic           lower_arrived;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            below[c] = (ID_W'(c) < sel_id);
        end
        lower_arrived = |(pend_vec & ~pend_q & below);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            sel_id <= '0;
            hold   <= 1'b0;
        end else begin
            pend_q <= pend_vec;
            if (wr_en) begin
                sel_id <= wr_id;
                hold   <= ~wr_clears;
            end else if (!hold) begin
                sel_id <= any_pend ? lowest : '0;
            end else if (lower_arrived) begin
                sel_id <= lowest;
                hold   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_irq_pend_sel.sv
module dma_irq_pend_sel
    import irqsel_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [NCH-1:0]    set_err,
    input  logic [NCH-1:0]    set_done,
    input  logic [NCH-1:0]    set_pause,
    input  logic [NCH-1:0]    set_integ,
    input  logic [NCH-1:0]    stat_pend,
    input  logic [NCH-1:0]    stat_busy,
    input  logic [NCH-1:0]    stat_fault,
    output logic              irq
);

    ch_flags_t [NCH-1:0] flags;
    logic [NCH-1:0]      pend_vec;
    logic                any_pend;
    logic [ID_W-1:0]     lowest;
    logic [ID_W-1:0]     sel_id;
    logic                view_hold;
    ch_flags_t           clr_bits;
    ch_flags_t           sel_flags;
    ch_stat_t            sel_stat;
    logic                unused_wr_bits;

    assign clr_bits       = clear_mask(wr_data);
    assign unused_wr_bits = ^{wr_data[15:13], wr_data[11], wr_data[7:5]};

    irqsel_flag_bank #(.NCH(NCH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_err  (set_err),
        .set_done (set_done),
        .set_pause(set_pause),
        .set_integ(set_integ),
        .clr_en   (wr_en),
        .clr_ch   (wr_data[ID_W-1:0]),
        .clr_bits (clr_bits),
        .flags    (flags),
        .pend_vec (pend_vec)
    );

    irqsel_prio_enc #(.NCH(NCH)) u_enc (
        .req  (pend_vec),
        .found(any_pend),
        .idx  (lowest)
    );

    irqsel_id_track #(.NCH(NCH)) u_track (
        .clk      (clk),
        .rst      (rst),
        .pend_vec (pend_vec),
        .any_pend (any_pend),
        .lowest   (lowest),
        .wr_en    (wr_en),
        .wr_id    (wr_data[ID_W-1:0]),
        .wr_clears(|clr_bits),
        .sel_id   (sel_id),
        .hold     (view_hold)
    );

    // an ID with no matching channel selects all-zero flags and status
    always_comb begin
        sel_flags = '0;
        sel_stat  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel_id == ID_W'(c)) begin
                sel_flags      = flags[c];
                sel_stat.pend  = stat_pend[c];
                sel_stat.busy  = stat_busy[c];
                sel_stat.fault = stat_fault[c];
            end
        end
    end

    assign rd_data = pack_word(sel_flags, sel_stat, sel_id);
    assign irq     = any_pend;

endmodule

// File: rtl/dma_irq_pend_sel_chk.sv
module dma_irq_pend_sel_chk
    import irqsel_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic [NCH-1:0]    set_err,
    input logic [NCH-1:0]    set_done,
    input logic [NCH-1:0]    set_pause,
    input logic              irq,
    input logic              hold
);

    // R1: reset leaves no pending interrupt behind
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq);

    // R2: bits 11 and 7:5 never read 1
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[11] == 1'b0 && rd_data[7:5] == 3'b000);

    // R9: a write lands in the ID field on the next edge
    a_r9_write_selects: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[ID_W-1:0] == $past(wr_data[ID_W-1:0]));

    // R11: a clearing write hands control back to automatic mode
    a_r11_clear_releases: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data[B_INTEG] || wr_data[B_PAUSE] ||
                   wr_data[B_DONE]  || wr_data[B_ERR])) |=> !hold);

    // R8: automatic mode with nothing pending yields ID zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !hold && !irq) |=> rd_data[ID_W-1:0] == '0);

    // R4: irq only rises after a set pulse
    a_r4_rise_has_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(set_err | set_done | set_pause)));

    // R12: irq only falls after a write
    a_r12_fall_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en));

endmodule

bind dma_irq_pend_sel dma_irq_pend_sel_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .set_err  (set_err),
    .set_done (set_done),
    .set_pause(set_pause),
    .irq      (irq),
    .hold     (view_hold)
);

// File: tb/dma_irq_pend_sel_tb.sv
module dma_irq_pend_sel_tb;

    localparam int NCH = 8;
    localparam int NV  = 22;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [NCH-1:0] set_err = '0, set_done = '0, set_pause = '0, set_integ = '0;
    logic [NCH-1:0] stat_pend = '0, stat_busy = '0, stat_fault = '0;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    dma_irq_pend_sel #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .set_err(set_err), .set_done(set_done), .set_pause(set_pause),
        .set_integ(set_integ), .stat_pend(stat_pend), .stat_busy(stat_busy),
        .stat_fault(stat_fault), .irq(irq)
    );

    // {err, done, pause, integ, wr_en, wr_data, exp_rd, exp_irq, req}
    localparam logic [73:0] VEC [NV] = '{
        {8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0205, 1'b1, 8'd4},  // R4 done ch5
        {8'h08, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0103, 1'b1, 8'd7},  // R7 lower ch3
        {8'h00, 8'h00, 8'h00, 8'h08, 1'b0, 16'h0000, 16'h1103, 1'b1, 8'd2},  // R2 integ ch3
        {8'h00, 8'h00, 8'h40, 8'h00, 1'b0, 16'h0000, 16'h1103, 1'b1, 8'd7},  // R7 higher ch6
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0003, 16'h1103, 1'b1, 8'd5},  // R5 zero write
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0103, 16'h0205, 1'b1, 8'd11}, // R11 clear err3
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0003, 16'h1003, 1'b1, 8'd9},  // R9 view ch3
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h1003, 16'h0205, 1'b1, 8'd5},  // R5 clear integ
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0006, 16'h0406, 1'b1, 8'd9},  // R9 view ch6
        {8'h00, 8'h02, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0201, 1'b1, 8'd10}, // R10 ch1 arrives
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0007, 16'h0007, 1'b1, 8'd9},  // R9 view ch7
        {8'h80, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0107, 1'b1, 8'd10}, // R10 same ch stays
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0201, 16'h0205, 1'b1, 8'd7},  // R7 next lowest
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0205, 16'h0406, 1'b1, 8'd7},  // R7
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0406, 16'h0107, 1'b1, 8'd7},  // R7
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0107, 16'h0000, 1'b0, 8'd8},  // R8 R12 all clear
        {8'h04, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0102, 16'h0102, 1'b1, 8'd6},  // R6 set wins
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0102, 16'h0000, 1'b0, 8'd12}, // R12
        {8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h0200, 1'b1, 8'd4},  // R4 ch0
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0214, 16'h0200, 1'b1, 8'd13}, // R13 bad clear
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0014, 16'h0014, 1'b1, 8'd13}, // R13 bad view
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 16'h0200, 16'h0000, 1'b0, 8'd12}  // R12
    };

    task automatic check(input int req, input logic [16:0] act, input logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: got {irq,rd}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic step_write(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, {irq, rd_data}, 17'h0_0000); // R1 during reset
        rst = 1'b0;
        @(negedge clk);
        check(1, {irq, rd_data}, 17'h0_0000); // R1 after reset

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_err   = VEC[i][73:66];
            set_done  = VEC[i][65:58];
            set_pause = VEC[i][57:50];
            set_integ = VEC[i][49:42];
            wr_en     = VEC[i][41];
            wr_data   = VEC[i][40:25];
            @(negedge clk);
            set_err = '0; set_done = '0; set_pause = '0; set_integ = '0;
            wr_en = 1'b0; wr_data = '0;
            @(negedge clk);
            check(int'(VEC[i][7:0]), {irq, rd_data}, {VEC[i][8], VEC[i][24:9]});
        end

        // R2: write data in the unused bits does not show up
        step_write(16'h08E0);
        check(2, {irq, rd_data}, 17'h0_0000);

        // R3: status levels of the viewed channel
        stat_busy = 8'hA5; stat_pend = 8'h0F; stat_fault = 8'hC0;
        step_write(16'h0007);
        check(3, {irq, rd_data}, 17'h0_6007);
        step_write(16'h0000);
        check(3, {irq, rd_data}, 17'h0_C000);
        step_write(16'h0006);
        check(3, {irq, rd_data}, 17'h0_2006);
        step_write(16'h0015);
        check(13, {irq, rd_data}, 17'h0_0015); // R13 status masked too

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule